// File: doc/BRIEF.md
# Flash Operation Status Read Path

This block produces the byte a host sees when it reads a flash device. While an internal program or erase operation is running, the array contents cannot be read. The host reads instead a status byte that carries two completion indicators. Bit 7 carries the complement of the data bit being written. Bit 6 flips on every read for as long as the operation lasts. The host may poll at any point in the operation. It can stop when bit 6 reads the same twice, or when bit 7 matches the data it wrote.

When no operation is running, the block returns the array data. In identification mode it instead returns a fixed manufacturer code, a fixed device code, or the boot-region lockout flag, chosen by the read address. The array itself and the command decoding sit outside this block. They supply the busy flag, the operation type, the last byte loaded for programming, the array data, the mode flag and the lockout flag.

Reads are single strobes with no back-pressure. A one-cycle `rd_stb` is answered with `rd_valid` and `rd_data` exactly one clock later. There is no ready signal, so the host must take each result in the cycle in which `rd_valid` is high. `rd_data` holds its value until the next strobe.

Top module: `flash_poll_read`

## Requirements
- R1: After reset, `rd_data` is 8'h00, `rd_valid` is 0, and the first read during the first operation returns bit 6 = 0.
- R2: `rd_valid` is 1 in exactly the cycle after each `rd_stb` cycle and 0 otherwise. `rd_data` keeps its value in the cycles between strobes.
- R3: While `busy`=1 and `op_is_erase`=0 (program), a read returns bit 7 = NOT `last_prog_data[7]` and bits 5..0 = 0.
- R4: While `busy`=1 and `op_is_erase`=1 (erase), a read returns bit 7 = 0 and bits 5..0 = 0.
- R5: While `busy`=1, bit 6 of each read is the inverse of bit 6 of the previous read in the same operation.
- R6: While `busy`=0 and `id_mode`=0, a read returns `array_data` unchanged on all eight bits.
- R7: When `busy`=1, the status byte is returned whatever the values of `id_mode` and `array_data`.
- R8: While `busy`=0 and `id_mode`=1, address 0 returns parameter `MFR_CODE` (default 8'hA5) and address 1 returns parameter `DEV_CODE` (default 8'h3C).
- R9: While `busy`=0 and `id_mode`=1, address 2 returns `lockout` on bit 0 (1 = locked) with bits 7..1 = 0.
- R10: While `busy`=0 and `id_mode`=1, any address other than 0, 1 or 2 returns 8'h00.
- R11: The toggle state is cleared while `busy`=0, so the first read of every operation returns bit 6 = 0. Clock cycles without a strobe do not change the toggle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Internal program or erase in progress |
| op_is_erase | input | 1 | Operation type: 1 = erase, 0 = program |
| last_prog_data | input | 8 | Last byte loaded for programming |
| array_data | input | 8 | True array read data |
| id_mode | input | 1 | Identification mode active |
| lockout | input | 1 | Boot-region lockout flag |
| rd_addr | input | ADDR_W (19) | Read address |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |

## Verification
A toggle flip-flop that is stuck shows up on the second busy read, when bit 6 repeats. A toggle flip-flop that is not cleared shows up on the first read of the next operation, when bit 6 reads 1. An error in the polarity or the bit position of bit 7 shows on the very first read of a program. A wrong source priority shows on the first busy read made while identification mode is on. Every such fault appears on `rd_data` one clock after the strobe that exposes it. The bench drives random sequences of operations and reads, with polls of random spacing. It also runs directed sequences for each address decode and for each priority case.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_IDENT  = 2'd2
  } rd_src_e;

  function automatic rd_src_e pick_source(input logic busy, input logic id_mode);
    if (busy)         return SRC_STATUS;
    else if (id_mode) return SRC_IDENT;
    else              return SRC_ARRAY;
  endfunction
endpackage

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_stb,
  output logic tog_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (!busy)  tog_q <= 1'b0;
    else if (rd_stb) tog_q <= ~tog_q;
  end

  p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_stb |=> tog_q != $past(tog_q));
  p_toggle_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !tog_q);
  p_toggle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rd_stb |=> $stable(tog_q));
endmodule

// File: rtl/fsr_status_fmt.sv
module fsr_status_fmt #(
  parameter int DATA_W = 8
) (
  input  logic              is_erase,
  input  logic [DATA_W-1:0] last_prog_data,
  input  logic              tog,
  output logic [DATA_W-1:0] status
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  always_comb begin
    status           = '0;
    status[POLL_BIT] = is_erase ? 1'b0 : ~last_prog_data[POLL_BIT];
    status[TOG_BIT]  = tog;
  end
endmodule

// File: rtl/fsr_ident.sv
module fsr_ident #(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 19,
  parameter logic [7:0]  MFR_CODE = 8'hA5,
  parameter logic [7:0]  DEV_CODE = 8'h3C
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              lockout,
  output logic [DATA_W-1:0] id_byte
);
  localparam logic [ADDR_W-1:0] A_MFR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEV  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(2);
  localparam int                LOCK_BIT = 0;

  always_comb begin
    id_byte = '0;
    if (addr == A_MFR)       id_byte = DATA_W'(MFR_CODE);
    else if (addr == A_DEV)  id_byte = DATA_W'(DEV_CODE);
    else if (addr == A_LOCK) id_byte[LOCK_BIT] = lockout;
  end
endmodule

// File: rtl/flash_poll_read.sv
module flash_poll_read #(
  parameter int         DATA_W   = 8,
  parameter int         ADDR_W   = 19,
  parameter logic [7:0] MFR_CODE = 8'hA5,
  parameter logic [7:0] DEV_CODE = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              op_is_erase,
  input  logic [DATA_W-1:0] last_prog_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              id_mode,
  input  logic              lockout,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_stb,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  import fsr_pkg::*;

  logic              tog;
  logic [DATA_W-1:0] status_b;
  logic [DATA_W-1:0] ident_b;
  logic [DATA_W-1:0] next_b;
  rd_src_e           src;

  fsr_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_stb(rd_stb), .tog_q(tog)
  );

  fsr_status_fmt #(.DATA_W(DATA_W)) u_status (
    .is_erase(op_is_erase), .last_prog_data(last_prog_data),
    .tog(tog), .status(status_b)
  );

  fsr_ident #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
              .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_ident (
    .addr(rd_addr), .lockout(lockout), .id_byte(ident_b)
  );

  always_comb begin
    src = pick_source(busy, id_mode);
    unique case (src)
      SRC_STATUS: next_b = status_b;
      SRC_IDENT:  next_b = ident_b;
      default:    next_b = array_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= next_b;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid && $stable(rd_data));
  p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy && !op_is_erase |=>
      rd_data[DATA_W-1] == ~$past(last_prog_data[DATA_W-1]) && rd_data[DATA_W-3:0] == '0);
  p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy && op_is_erase |=> !rd_data[DATA_W-1] && rd_data[DATA_W-3:0] == '0);
  p_array_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !busy && !id_mode |=> rd_data == $past(array_data));
  p_lock_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !busy && id_mode && rd_addr == ADDR_W'(2) |=>
      rd_data == {{(DATA_W-1){1'b0}}, $past(lockout)});
endmodule

// File: tb/tb_flash_poll_read.sv
`timescale 1ns/1ps
module tb_flash_poll_read;
  localparam int AW = 19;
  localparam logic [7:0] MFR = 8'hA5;
  localparam logic [7:0] DEV = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, op_is_erase = 1'b0, id_mode = 1'b0, lockout = 1'b0, rd_stb = 1'b0;
  logic [7:0] last_prog_data = 8'h00, array_data = 8'h00;
  logic [AW-1:0] rd_addr = '0;
  logic rd_valid;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  logic m_tog = 1'b0;
  logic [7:0] last_exp = 8'h00;
  logic [7:0] cur_exp;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_poll_read dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_is_erase(op_is_erase),
    .last_prog_data(last_prog_data), .array_data(array_data), .id_mode(id_mode),
    .lockout(lockout), .rd_addr(rd_addr), .rd_stb(rd_stb),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_byte(logic b, logic e, logic [7:0] last,
      logic [7:0] arr, logic id, logic lk, logic [AW-1:0] a, logic t);
    if (b) return {(e ? 1'b0 : ~last[7]), t, 6'b0};
    if (id) begin
      if (a == 0) return MFR;
      if (a == 1) return DEV;
      if (a == 2) return {7'b0, lk};
      return 8'h00;
    end
    return arr;
  endfunction

  function automatic string tag_of(logic b, logic e, logic id, logic [AW-1:0] a);
    if (b && id) return "R7";
    if (b && e)  return "R4";
    if (b)       return "R3";
    if (id && a <= 1) return "R8";
    if (id && a == 2) return "R9";
    if (id)      return "R10";
    return "R6";
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle; inputs already set after a negedge
  task automatic step(logic stb);
    string t;
    logic was_busy;
    rd_stb = stb;
    was_busy = busy;
    t = tag_of(busy, op_is_erase, id_mode, rd_addr);
    @(posedge clk);
    cur_exp = exp_byte(busy, op_is_erase, last_prog_data, array_data,
                       id_mode, lockout, rd_addr, m_tog);
    if (!busy) m_tog = 1'b0;
    else if (stb) m_tog = ~m_tog;
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R2", {7'b0, rd_valid}, {7'b0, stb});
    if (stb) begin
      chk(t, rd_data, cur_exp);
      if (was_busy) chk("R5", {7'b0, rd_data[6]}, {7'b0, cur_exp[6]});
      last_exp = cur_exp;
    end else begin
      chk("R2", rd_data, last_exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", rd_data, 8'h00);
    chk("R1", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;

    // directed: program polling
    busy = 1; op_is_erase = 0; last_prog_data = 8'h80;
    step(1);
    chk("R1", {7'b0, rd_data[6]}, 8'h00);
    step(1); step(0); step(0); step(1);
    last_prog_data = 8'h35; step(1);
    // precedence over id mode
    id_mode = 1; rd_addr = 0; array_data = 8'hFF; step(1); id_mode = 0;
    // idle: array
    busy = 0; array_data = 8'h5A; step(1); array_data = 8'hC3; step(1);
    // new op: toggle restarts at 0
    busy = 1; op_is_erase = 1; step(1);
    chk("R11", {7'b0, rd_data[6]}, 8'h00);
    step(0); step(0); step(1);
    chk("R11", {7'b0, rd_data[6]}, 8'h01);
    step(1);
    // identification reads
    busy = 0; id_mode = 1;
    rd_addr = 0; step(1); rd_addr = 1; step(1);
    rd_addr = 2; lockout = 0; step(1); lockout = 1; step(1);
    rd_addr = 3; step(1); rd_addr = 19'h7FFFF; step(1);
    id_mode = 0;

    // random
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        busy = ~busy;
        if (busy) op_is_erase = $urandom_range(0, 1);
      end
      last_prog_data = 8'($urandom);
      array_data = 8'($urandom);
      id_mode = ($urandom_range(0, 3) == 0);
      lockout = $urandom_range(0, 1);
      case ($urandom_range(0, 4))
        0: rd_addr = 0;
        1: rd_addr = 1;
        2: rd_addr = 2;
        3: rd_addr = 3;
        default: rd_addr = AW'($urandom);
      endcase
      step($urandom_range(0, 1));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule